// File: doc/BRIEF.md
# Jittered Foldback PWM Cycle Generator

This block sets the timing of every switching cycle of a peak-current-mode converter. A free-running reference clock counts out each period. The period length comes from the digitised feedback level, which an external converter delivers as a code. Each period starts with an on-window. The on-window is closed early by a trip pulse from the current comparator, or at the latest by a fixed duty ceiling. The block drives a gate-enable output and a ramp-active flag for the downstream driver and the slope-compensation circuit.

At heavy load the period follows one of two selectable nominal rates. As the feedback level falls, the switching frequency drops linearly to a fixed floor. A second foldback profile starts earlier and reaches the floor sooner. A slow triangular offset is added to every period, including during foldback, to spread conducted emissions. At very light load, whole cycles are dropped. Skipping starts below one feedback level and stops only once the level has risen a hysteresis step above it.

With the default 13 MHz reference, the nominal periods are 200 counts (65 kHz) and 130 counts (100 kHz), and the floor period is 500 counts (26 kHz).

Top module: `pwm_fold_gen`

## Requirements
- R1: While `rst` is high, and for the whole first period after it falls (500 reference cycles with defaults), both `gate_en` and `ramp_on` are low.
- R2: When `fb_code` is at or above the fold start (750, which is 1.5 V at 2 mV per LSB), the mean period is REF_HZ/65 kHz when `rate_fast`=0 and REF_HZ/100 kHz when `rate_fast`=1, within one reference cycle.
- R3: A triangular offset is added to each period. It moves one count per step, and by default one step is taken every few cycles, which gives a sweep of about 240 Hz. Its peak is ±floor(5 % of the selected nominal period in counts): 10 counts at 65 kHz and 6 counts at 100 kHz. Over one sweep, the longest and shortest periods differ by exactly twice that peak.
- R4: With `early_fold`=0, the target frequency is linear in `fb_code` between code 175 (350 mV, where it equals 26 kHz) and code 750 (where it equals the nominal rate). It stays at 26 kHz for any code at or below 175. The mean period equals REF_HZ divided by that frequency, within one cycle.
- R5: The triangular offset keeps its full swing while the frequency is folded back.
- R6: With `early_fold`=1, the same linear law applies between code 750 (1.5 V, 26 kHz) and code 950 (1.9 V, nominal rate).
- R7: In every cycle that is not skipped, `ramp_on` rises at the start of the period and stays high for floor(80 % × that period) cycles. Without a trip, `gate_en` has the same width.
- R8: If `trip` is sampled high while `gate_en` is high, `gate_en` is low from the next cycle until the period ends, and `ramp_on` is not affected. A trip sampled outside the on-window has no effect on the next cycle.
- R9: Once `fb_code` drops below 150 (300 mV), whole periods are skipped: both outputs stay low for every skipped period, and the skip decision takes effect only at a period boundary.
- R10: Skipping continues until `fb_code` reaches 165 (330 mV). A code between 150 and 164 holds whichever state, skipping or switching, was in force before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that counts out the period |
| rst | input | 1 | Synchronous active-high reset |
| fb_code | input | FB_W (12) | Feedback level code, 2 mV per LSB |
| rate_fast | input | 1 | 0 selects a 65 kHz nominal rate, 1 selects 100 kHz |
| early_fold | input | 1 | 1 selects the foldback profile that runs from 1.9 V to 1.5 V |
| trip | input | 1 | Current-comparator trip pulse, sampled on clk |
| gate_en | output | 1 | Registered enable for the power-switch driver |
| ramp_on | output | 1 | Registered flag, high for the full allowed on-window |

## Verification
A fault in the frequency map or the divider shows at the next period boundary as a shifted mean period. The bench finds it by taking the centre of the extremes over one full dither sweep. A stuck or clipped triangle offset shows within one sweep (4 × peak periods) as an excursion that is too small or too large. A duty-ceiling or trip-path error shows in the very cycle it affects, as a `ramp_on` or `gate_en` width that differs from floor(0.8 × period). A wrong skip state shows within two periods as pulses where none are due, or as silence where pulses are due. The bench tests this on both sides of the hysteresis band.

// File: rtl/pwm_fold_pkg.sv
package pwm_fold_pkg;

  // States of the sequential reciprocal divider
  typedef enum logic [1:0] {
    DIV_LOAD = 2'd0,
    DIV_RUN  = 2'd1,
    DIV_DONE = 2'd2
  } div_state_e;

  // Integer percentage of a count, rounded down
  function automatic int pct_of(input int value, input int pct);
    return (value * pct) / 100;
  endfunction

endpackage

// File: rtl/pwm_fold_map.sv
module pwm_fold_map
  import pwm_fold_pkg::*;
#(
  parameter int FB_W         = 12,
  parameter int MV_PER_LSB   = 2,
  parameter int SLOW_HZ      = 65000,
  parameter int FAST_HZ      = 100000,
  parameter int FLOOR_HZ     = 26000,
  parameter int FOLD_HI_MV   = 1500,
  parameter int FOLD_LO_MV   = 350,
  parameter int ALT_HI_MV    = 1900,
  parameter int ALT_LO_MV    = 1500,
  parameter int SKIP_MV      = 300,
  parameter int SKIP_HYST_MV = 30,
  parameter int FW           = 17
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [FB_W-1:0] fb_code,
  input  logic            rate_fast,
  input  logic            early_fold,
  output logic [FW-1:0]   f_tgt,
  output logic            skip_req
);

  localparam int HI_N   = FOLD_HI_MV / MV_PER_LSB;
  localparam int LO_N   = FOLD_LO_MV / MV_PER_LSB;
  localparam int HI_A   = ALT_HI_MV / MV_PER_LSB;
  localparam int LO_A   = ALT_LO_MV / MV_PER_LSB;
  localparam int SKIP_N = SKIP_MV / MV_PER_LSB;
  localparam int REL_N  = (SKIP_MV + SKIP_HYST_MV) / MV_PER_LSB;
  // slopes in Hz per code, 8 fractional bits
  localparam int SL_SN  = ((SLOW_HZ - FLOOR_HZ) * 256) / (HI_N - LO_N);
  localparam int SL_SA  = ((SLOW_HZ - FLOOR_HZ) * 256) / (HI_A - LO_A);
  localparam int SL_FN  = ((FAST_HZ - FLOOR_HZ) * 256) / (HI_N - LO_N);
  localparam int SL_FA  = ((FAST_HZ - FLOOR_HZ) * 256) / (HI_A - LO_A);

  int fbv, hi, lo, nom, slope, f_c;

  always_comb begin
    fbv = int'(fb_code);
    hi  = early_fold ? HI_A : HI_N;
    lo  = early_fold ? LO_A : LO_N;
    nom = rate_fast ? FAST_HZ : SLOW_HZ;
    case ({rate_fast, early_fold})
      2'b00:   slope = SL_SN;
      2'b01:   slope = SL_SA;
      2'b10:   slope = SL_FN;
      default: slope = SL_FA;
    endcase
    if (fbv >= hi)      f_c = nom;
    else if (fbv <= lo) f_c = FLOOR_HZ;
    else                f_c = FLOOR_HZ + (((fbv - lo) * slope) >>> 8);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      f_tgt    <= FW'(FLOOR_HZ);
      skip_req <= 1'b0;
    end else begin
      f_tgt <= FW'(f_c);
      if (skip_req) begin
        if (fbv >= REL_N) skip_req <= 1'b0;
      end else if (fbv < SKIP_N) begin
        skip_req <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_fold_div.sv
module pwm_fold_div
  import pwm_fold_pkg::*;
#(
  parameter int DIVIDEND = 13000000,
  parameter int FW       = 17,
  parameter int PW       = 10,
  parameter int RESET_Q  = 500
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] divisor,
  output logic [PW-1:0] quot
);

  localparam int DW = $clog2(DIVIDEND + 1);
  localparam int IW = $clog2(DW);
  localparam logic [DW-1:0] DVD  = DW'(DIVIDEND);
  localparam logic [DW-1:0] QMAX = DW'((1 << PW) - 1);

  div_state_e    st;
  logic [FW-1:0] rem;
  logic [FW-1:0] dsr;
  logic [DW-1:0] quo;
  logic [IW-1:0] idx;
  logic [FW:0]   trial;

  assign trial = {rem, DVD[idx]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= DIV_LOAD;
      rem  <= '0;
      dsr  <= FW'(1);
      quo  <= '0;
      idx  <= '0;
      quot <= PW'(RESET_Q);
    end else begin
      case (st)
        DIV_LOAD: begin
          dsr <= (divisor == '0) ? FW'(1) : divisor;
          rem <= '0;
          quo <= '0;
          idx <= IW'(DW - 1);
          st  <= DIV_RUN;
        end
        DIV_RUN: begin
          if (trial >= {1'b0, dsr}) begin
            rem      <= FW'(trial - {1'b0, dsr});
            quo[idx] <= 1'b1;
          end else begin
            rem <= trial[FW-1:0];
          end
          if (idx == '0) st <= DIV_DONE;
          else           idx <= idx - IW'(1);
        end
        default: begin
          quot <= (quo > QMAX) ? '1 : quo[PW-1:0];
          st   <= DIV_LOAD;
        end
      endcase
    end
  end

endmodule

// File: rtl/pwm_fold_dither.sv
module pwm_fold_dither #(
  parameter int AMP_SLOW = 10,
  parameter int AMP_FAST = 6,
  parameter int DIV      = 6,
  parameter int OW       = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic                 rate_fast,
  output logic signed [OW-1:0] off
);

  localparam logic signed [OW-1:0] A_S = OW'(AMP_SLOW);
  localparam logic signed [OW-1:0] A_F = OW'(AMP_FAST);

  logic                 tick;
  logic                 up;
  logic signed [OW-1:0] amp;

  assign amp = rate_fast ? A_F : A_S;

  generate
    if (DIV <= 1) begin : g_direct
      assign tick = step;
    end else begin : g_prescale
      localparam int DVW = $clog2(DIV);
      logic [DVW-1:0] pc;
      assign tick = step && (pc == DVW'(DIV - 1));
      always_ff @(posedge clk) begin
        if (rst)       pc <= '0;
        else if (step) pc <= (pc == DVW'(DIV - 1)) ? '0 : pc + DVW'(1);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      off <= '0;
      up  <= 1'b1;
    end else if (tick) begin
      if (up) begin
        if (off >= amp) begin
          up  <= 1'b0;
          off <= off - OW'(1);
        end else begin
          off <= off + OW'(1);
        end
      end else begin
        if (off <= -amp) begin
          up  <= 1'b1;
          off <= off + OW'(1);
        end else begin
          off <= off - OW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/pwm_fold_gen.sv
module pwm_fold_gen
  import pwm_fold_pkg::*;
#(
  parameter int REF_HZ       = 13000000,
  parameter int SLOW_HZ      = 65000,
  parameter int FAST_HZ      = 100000,
  parameter int FLOOR_HZ     = 26000,
  parameter int FB_W         = 12,
  parameter int MV_PER_LSB   = 2,
  parameter int FOLD_HI_MV   = 1500,
  parameter int FOLD_LO_MV   = 350,
  parameter int ALT_HI_MV    = 1900,
  parameter int ALT_LO_MV    = 1500,
  parameter int SKIP_MV      = 300,
  parameter int SKIP_HYST_MV = 30,
  parameter int DMAX_PCT     = 80,
  parameter int DITHER_PCT   = 5,
  parameter int SWEEP_HZ     = 240,
  parameter int DITHER_DIV   =
    (SLOW_HZ / (SWEEP_HZ * 4 * (((REF_HZ / SLOW_HZ) * DITHER_PCT) / 100))) < 1 ? 1 :
    (SLOW_HZ / (SWEEP_HZ * 4 * (((REF_HZ / SLOW_HZ) * DITHER_PCT) / 100)))
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [FB_W-1:0] fb_code,
  input  logic            rate_fast,
  input  logic            early_fold,
  input  logic            trip,
  output logic            gate_en,
  output logic            ramp_on
);

  localparam int P_SLOW   = REF_HZ / SLOW_HZ;
  localparam int P_FAST   = REF_HZ / FAST_HZ;
  localparam int P_FLOOR  = REF_HZ / FLOOR_HZ;
  localparam int AMP_SLOW = pct_of(P_SLOW, DITHER_PCT);
  localparam int AMP_FAST = pct_of(P_FAST, DITHER_PCT);
  localparam int PW       = $clog2(P_FLOOR + AMP_SLOW + 1) + 1;
  localparam int FW       = $clog2(FAST_HZ + 1);
  localparam int OW       = $clog2(AMP_SLOW + 1) + 2;

  logic [FW-1:0]        f_tgt;
  logic                 skip_req;
  logic [PW-1:0]        base;
  logic signed [OW-1:0] off;

  logic [PW-1:0] cnt;
  logic [PW-1:0] per_cur;
  logic [PW-1:0] ton_cur;
  logic          skip_cur;
  logic          last;
  int            pn, tn;

  pwm_fold_map #(
    .FB_W(FB_W), .MV_PER_LSB(MV_PER_LSB), .SLOW_HZ(SLOW_HZ), .FAST_HZ(FAST_HZ),
    .FLOOR_HZ(FLOOR_HZ), .FOLD_HI_MV(FOLD_HI_MV), .FOLD_LO_MV(FOLD_LO_MV),
    .ALT_HI_MV(ALT_HI_MV), .ALT_LO_MV(ALT_LO_MV), .SKIP_MV(SKIP_MV),
    .SKIP_HYST_MV(SKIP_HYST_MV), .FW(FW)
  ) u_map (
    .clk(clk), .rst(rst), .fb_code(fb_code), .rate_fast(rate_fast),
    .early_fold(early_fold), .f_tgt(f_tgt), .skip_req(skip_req)
  );

  pwm_fold_div #(
    .DIVIDEND(REF_HZ), .FW(FW), .PW(PW), .RESET_Q(P_FLOOR)
  ) u_div (
    .clk(clk), .rst(rst), .divisor(f_tgt), .quot(base)
  );

  pwm_fold_dither #(
    .AMP_SLOW(AMP_SLOW), .AMP_FAST(AMP_FAST), .DIV(DITHER_DIV), .OW(OW)
  ) u_dither (
    .clk(clk), .rst(rst), .step(last), .rate_fast(rate_fast), .off(off)
  );

  assign last = (cnt == per_cur - PW'(1));

  always_comb begin
    pn = int'(base) + int'(off);
    tn = pct_of(pn, DMAX_PCT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      per_cur  <= PW'(P_FLOOR);
      ton_cur  <= PW'(pct_of(P_FLOOR, DMAX_PCT));
      skip_cur <= 1'b1;
      gate_en  <= 1'b0;
      ramp_on  <= 1'b0;
    end else if (last) begin
      cnt      <= '0;
      per_cur  <= PW'(pn);
      ton_cur  <= PW'(tn);
      skip_cur <= skip_req;
      gate_en  <= !skip_req;
      ramp_on  <= !skip_req;
    end else begin
      cnt <= cnt + PW'(1);
      if ((cnt + PW'(1)) == ton_cur) begin
        gate_en <= 1'b0;
        ramp_on <= 1'b0;
      end else if (trip) begin
        gate_en <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pwm_fold_chk.sv
module pwm_fold_chk #(
  parameter int PW       = 10,
  parameter int OW       = 6,
  parameter int P_FAST   = 130,
  parameter int P_FLOOR  = 500,
  parameter int AMP_SLOW = 10,
  parameter int AMP_FAST = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 trip,
  input logic                 gate_en,
  input logic                 ramp_on,
  input logic [PW-1:0]        cnt,
  input logic [PW-1:0]        per_cur,
  input logic [PW-1:0]        ton_cur,
  input logic                 skip_cur,
  input logic signed [OW-1:0] off
);

  localparam logic signed [OW-1:0] A_S   = OW'(AMP_SLOW);
  localparam logic [PW-1:0]        P_MIN = PW'(P_FAST - AMP_FAST);
  localparam logic [PW-1:0]        P_MAX = PW'(P_FLOOR + AMP_SLOW);

  assert_rise_at_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ramp_on) |-> (cnt == '0));

  assert_duty_cap_R7: assert property (@(posedge clk) disable iff (rst)
    ramp_on |-> (cnt < ton_cur) && (ton_cur < per_cur));

  assert_gate_in_window_R8: assert property (@(posedge clk) disable iff (rst)
    gate_en |-> ramp_on);

  assert_trip_cut_R8: assert property (@(posedge clk) disable iff (rst)
    (trip && gate_en && (cnt != per_cur - PW'(1))) |=> !gate_en);

  assert_skip_idle_R9: assert property (@(posedge clk) disable iff (rst)
    skip_cur |-> (!ramp_on && !gate_en));

  assert_dither_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (off <= A_S) && (off >= -A_S));

  assert_dither_step_R3: assert property (@(posedge clk) disable iff (rst)
    (off != $past(off)) |-> ((off == $past(off) + OW'(1)) || (off == $past(off) - OW'(1))));

  assert_period_range_R4: assert property (@(posedge clk) disable iff (rst)
    (per_cur >= P_MIN) && (per_cur <= P_MAX));

endmodule

bind pwm_fold_gen pwm_fold_chk #(
  .PW(PW), .OW(OW), .P_FAST(P_FAST), .P_FLOOR(P_FLOOR),
  .AMP_SLOW(AMP_SLOW), .AMP_FAST(AMP_FAST)
) u_chk (
  .clk(clk), .rst(rst), .trip(trip), .gate_en(gate_en), .ramp_on(ramp_on),
  .cnt(cnt), .per_cur(per_cur), .ton_cur(ton_cur), .skip_cur(skip_cur), .off(off)
);

// File: tb/pwm_fold_gen_tb.sv
`timescale 1ns/1ps
module pwm_fold_gen_tb;

  localparam int NV     = 7;
  localparam int V_FAST [NV] = '{1, 1, 0, 0, 0, 0, 0};
  localparam int V_ALT  [NV] = '{0, 1, 0, 0, 1, 1, 0};
  localparam int V_FB   [NV] = '{1000, 850, 1000, 462, 1000, 800, 160};
  localparam int AMP_S  = 10;
  localparam int AMP_F  = 6;
  localparam int WD     = 195000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trip = 1'b0;
  logic        rate_fast = 1'b1;
  logic        early_fold = 1'b0;
  logic [11:0] fb_code = 12'd1000;
  logic        gate_en, ramp_on;

  int     n_chk = 0;
  int     n_fail = 0;
  longint cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_fold_gen #(.DITHER_DIV(1)) u_dut (
    .clk(clk), .rst(rst), .fb_code(fb_code), .rate_fast(rate_fast),
    .early_fold(early_fold), .trip(trip), .gate_en(gate_en), .ramp_on(ramp_on)
  );

  task automatic chk(input bit ok, input string tag, input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0.2f expected=%0.2f", tag, act, exp);
    end
  endtask

  function automatic real exp_period(input int fast, input int alt, input int fb);
    real nom, f;
    int  hi, lo;
    nom = (fast != 0) ? 100000.0 : 65000.0;
    hi  = (alt != 0) ? 950 : 750;
    lo  = (alt != 0) ? 750 : 175;
    if (fb >= hi)      f = nom;
    else if (fb <= lo) f = 26000.0;
    else               f = 26000.0 + (nom - 26000.0) * real'(fb - lo) / real'(hi - lo);
    return 13.0e6 / f;
  endfunction

  task automatic next_rise();
    logic pr;
    pr = ramp_on;
    forever begin
      @(negedge clk);
      if (ramp_on && !pr) break;
      pr = ramp_on;
    end
  endtask

  // called at a rise; returns at the following rise
  task automatic measure_period(output int per, output int rw, output int gw);
    int k;
    k = 0; rw = -1; gw = -1; per = 0;
    forever begin
      @(negedge clk);
      k++;
      if (!ramp_on && rw < 0) rw = k;
      if (!gate_en && gw < 0) gw = k;
      if (ramp_on && rw >= 0) begin
        per = k;
        break;
      end
    end
  endtask

  task automatic count_rises(input int n, output int c);
    logic pr;
    pr = ramp_on;
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (ramp_on && !pr) c++;
      pr = ramp_on;
    end
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<%0d", WD, WD);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int  p, rw, gw, mn, mx, bad, amp, c;
    real ctr, ep;
    bit  folded;

    // R1: reset state
    repeat (4) @(negedge clk);
    chk(!gate_en && !ramp_on, "R1 outputs low in reset", real'(gate_en | ramp_on), 0.0);
    rst = 1'b0;
    c = 0;
    repeat (400) begin
      @(negedge clk);
      if (ramp_on || gate_en) c++;
    end
    chk(c == 0, "R1 first period idle", real'(c), 0.0);

    // vector table: period, dither excursion, duty ceiling
    for (int v = 0; v < NV; v++) begin
      rate_fast  = (V_FAST[v] != 0);
      early_fold = (V_ALT[v] != 0);
      fb_code    = 12'(V_FB[v]);
      amp        = rate_fast ? AMP_F : AMP_S;
      folded     = (V_FB[v] < (early_fold ? 950 : 750));
      repeat (8) next_rise();
      mn = 100000; mx = 0; bad = 0;
      for (int k = 0; k < 4 * amp + 2; k++) begin
        measure_period(p, rw, gw);
        if (p < mn) mn = p;
        if (p > mx) mx = p;
        if ((rw != (p * 80) / 100) || (gw != rw)) bad++;
      end
      ctr = (real'(mn) + real'(mx)) / 2.0;
      ep  = exp_period(V_FAST[v], V_ALT[v], V_FB[v]);
      chk((ctr - ep <= 1.01) && (ep - ctr <= 1.01),
          !folded ? "R2 nominal period" : (early_fold ? "R6 early foldback period" : "R4 foldback period"),
          ctr, ep);
      chk((mx - mn) == 2 * amp, folded ? "R5 dither swing in foldback" : "R3 dither swing",
          real'(mx - mn), real'(2 * amp));
      chk(bad == 0, "R7 on-window width is 80 percent", real'(bad), 0.0);
    end

    // R8: trip inside and outside the on-window
    rate_fast = 1'b0; early_fold = 1'b0; fb_code = 12'd1000;
    repeat (4) next_rise();
    repeat (20) @(negedge clk);
    trip = 1'b1;
    @(negedge clk);
    trip = 1'b0;
    chk(!gate_en && ramp_on, "R8 trip cuts gate, ramp stays", real'({gate_en, ramp_on}), 1.0);
    c = 0;
    while (ramp_on) begin
      @(negedge clk);
      if (gate_en) c++;
    end
    chk(c == 0, "R8 gate stays off after trip", real'(c), 0.0);
    repeat (5) @(negedge clk);
    trip = 1'b1;
    repeat (3) @(negedge clk);
    trip = 1'b0;
    next_rise();
    chk(gate_en, "R8 gate restarts next period", real'(gate_en), 1.0);
    measure_period(p, rw, gw);
    chk((gw == rw) && (rw == (p * 80) / 100), "R8 off-window trip has no effect", real'(gw), real'((p * 80) / 100));

    // R9/R10: skip with hysteresis
    fb_code = 12'd140;
    count_rises(1100, c);
    count_rises(1600, c);
    chk(c == 0, "R9 cycles skipped below 150", real'(c), 0.0);
    fb_code = 12'd160;
    count_rises(1600, c);
    chk(c == 0, "R10 skip held inside band", real'(c), 0.0);
    fb_code = 12'd170;
    count_rises(1200, c);
    chk(c >= 1, "R10 skip released at 165", real'(c), 1.0);
    fb_code = 12'd158;
    count_rises(600, c);
    count_rises(1600, c);
    chk(c >= 2, "R10 switching held inside band", real'(c), 2.0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule